// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block decides when a chip comes out of reset after power is applied. Two comparator flags report that the supply has crossed the power-on level and the brown-out level. The block holds the system reset high through a fixed chain of extension stages: a power-on extension, a brown-out extension, and a power-up timer whose length is selected by a 3-bit input. It then drops reset, which lets the oscillator start. Once the oscillator reports ready, the block flags run. A further delay later, it opens the clock-failure monitor if that monitor is requested.

All delays are counted in ticks of a free-running reference strobe. The strobe is sampled once per clock. Every stage shares one counter, and the counter restarts at each change of stage. If a supply flag is lost, the sequence falls back to the first stage. If the oscillator stays silent past a timeout, the block raises a clock-fail flag and parks.

Top module: `por_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, the stage code is 0, `sys_rst` is 1, and `osc_enable`, `run`, `fscm_enable` and `clk_fail` are 0.
- R2: The stage codes are 0 = power-on hold, 1 = brown-out hold, 2 = power-up timer, 3 = oscillator wait, 4 = run, 5 = monitored run. The code only steps up by one, or returns to 0.
- R3: Stage 0 counts ticks only while `por_ok` is high; while `por_ok` is low the count stays at zero. It lasts POR_TICKS+1 cycles when `por_ok` is high and `tick` is high every cycle.
- R4: Stage 1 counts ticks only while `bor_ok` is high. While `bor_ok` is low the count is held at zero and the stage does not end. It lasts BOR_TICKS+1 cycles when `bor_ok` is high and `tick` is high every cycle.
- R5: Stage 2 lasts L+1 cycles under continuous ticks. L is 0 when `pwrt_sel` is 0; otherwise L is PWRT_UNIT times 2 to the power (`pwrt_sel`-1). `sys_rst` is 1 in stages 0 to 2 and drops on entry to stage 3. `osc_enable` is 1 from stage 3 onward.
- R6: A cycle with `tick` low leaves the stage count unchanged, so the stage stretches by that many cycles.
- R7: In stage 3, `osc_ready` high at a clock edge moves the block to stage 4 at that edge. `run` is 1 in stages 4 and 5. `start_vec` is 0.
- R8: If `osc_ready` has not arrived, `clk_fail` rises OSC_TIMEOUT+1 cycles after stage 3 is entered. From then on the block stays in stage 3 and ignores `osc_ready`. `clk_fail` stays high until reset or a supply fault.
- R9: Stage 4 lasts MON_TICKS+1 cycles under continuous ticks. In stage 5, `fscm_enable` equals `fscm_req`; in every other stage it is 0.
- R10: Either of two supply faults moves the block to stage 0 at the next edge, with `sys_rst` high, the count restarted and `clk_fail` cleared. The faults are `por_ok` low in any stage, and `bor_ok` low in stage 2 or later. `bor_ok` low in stage 0 is not a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick strobe, one count per high cycle |
| por_ok | input | 1 | Supply above power-on level |
| bor_ok | input | 1 | Supply above brown-out level |
| pwrt_sel | input | 3 | Power-up timer length select |
| osc_ready | input | 1 | Oscillator clock is stable |
| fscm_req | input | 1 | Clock-failure monitoring wanted |
| sys_rst | output | 1 | System reset, active high |
| osc_enable | output | 1 | Oscillator may run |
| run | output | 1 | Core may execute |
| fscm_enable | output | 1 | Clock-failure monitor on |
| clk_fail | output | 1 | Oscillator timeout, sticky |
| start_vec | output | VEC_W | Fetch address after reset |
| state_o | output | 3 | Current stage code |

## Verification
The bench sweeps all eight timer selects. In each pass it measures every stage length in cycles and compares it with arithmetic from the parameters. An off-by-one in the end-of-stage compare, or a wrong power of two for the timer, would show up as a miscounted dwell.

Other tests cover specific faults:
- It holds the supply flags low inside their own stages. A design that lets the count run, or treats a low `bor_ok` in the first stage as a fault, would leave too early or restart.
- It stalls the tick mid-stage. A design that still counts would end the timer early.
- It lets the oscillator time out and then raises `osc_ready`. A non-sticky fail path would slip into run.
- It drops each supply flag in late stages. A missed fault would leave reset released.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_BOR  = 3'd1,
    ST_PWRT = 3'd2,
    ST_OSCW = 3'd3,
    ST_RUN  = 3'd4,
    ST_MON  = 3'd5
  } stage_e;

  // power-up timer length in ticks for a given select code
  function automatic int unsigned pwrt_len(input logic [2:0] sel,
                                           input int unsigned unit);
    if (sel == 3'd0) return 0;
    return unit << (int'(sel) - 1);
  endfunction

  function automatic logic holds_reset(input stage_e s);
    return (s == ST_POR) || (s == ST_BOR) || (s == ST_PWRT);
  endfunction

  function automatic logic clocks_on(input stage_e s);
    return (s == ST_OSCW) || (s == ST_RUN) || (s == ST_MON);
  endfunction

  function automatic logic core_runs(input stage_e s);
    return (s == ST_RUN) || (s == ST_MON);
  endfunction

  // a stage at or past the timer watches the brown-out flag
  function automatic logic watches_bor(input stage_e s);
    return !((s == ST_POR) || (s == ST_BOR));
  endfunction

endpackage

// File: rtl/por_seq_timer.sv
module por_seq_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (tick && !done_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned POR_TICKS   = 3,
  parameter int unsigned BOR_TICKS   = 10,
  parameter int unsigned PWRT_UNIT   = 4,
  parameter int unsigned OSC_TIMEOUT = 50,
  parameter int unsigned MON_TICKS   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok,
  input  logic             bor_ok,
  input  logic [2:0]       pwrt_sel,
  input  logic             osc_ready,
  input  logic             stage_done,
  output stage_e           state_o,
  output logic [CNT_W-1:0] target_o,
  output logic             cnt_clr_o,
  output logic             supply_fault_o,
  output logic             fail_set_o,
  output logic             clk_fail_o
);

  localparam logic [CNT_W-1:0] POR_T = CNT_W'(POR_TICKS);
  localparam logic [CNT_W-1:0] BOR_T = CNT_W'(BOR_TICKS);
  localparam logic [CNT_W-1:0] OSC_T = CNT_W'(OSC_TIMEOUT);
  localparam logic [CNT_W-1:0] MON_T = CNT_W'(MON_TICKS);

  stage_e state_q, nxt;
  logic   fail_q;
  logic   hold;

  assign supply_fault_o = !por_ok || (watches_bor(state_q) && !bor_ok);

  always_comb begin
    case (state_q)
      ST_POR:  target_o = POR_T;
      ST_BOR:  target_o = BOR_T;
      ST_PWRT: target_o = CNT_W'(pwrt_len(pwrt_sel, PWRT_UNIT));
      ST_OSCW: target_o = OSC_T;
      ST_RUN:  target_o = MON_T;
      default: target_o = '0;
    endcase
  end

  always_comb begin
    nxt        = state_q;
    hold       = 1'b0;
    fail_set_o = 1'b0;
    if (supply_fault_o) begin
      nxt  = ST_POR;
      hold = 1'b1;
    end else begin
      case (state_q)
        ST_POR:  if (stage_done) nxt = ST_BOR;
        ST_BOR: begin
          if (!bor_ok)         hold = 1'b1;
          else if (stage_done) nxt  = ST_PWRT;
        end
        ST_PWRT: if (stage_done) nxt = ST_OSCW;
        ST_OSCW: begin
          if (!fail_q) begin
            if (osc_ready)       nxt        = ST_RUN;
            else if (stage_done) fail_set_o = 1'b1;
          end
        end
        ST_RUN:  if (stage_done) nxt = ST_MON;
        ST_MON:  nxt = ST_MON;
        default: nxt = ST_POR;
      endcase
    end
  end

  assign cnt_clr_o = hold || (nxt != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      fail_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      if (supply_fault_o)  fail_q <= 1'b0;
      else if (fail_set_o) fail_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign clk_fail_o = fail_q;

endmodule

// File: rtl/por_seq_outdec.sv
module por_seq_outdec
  import por_seq_pkg::*;
(
  input  stage_e state,
  input  logic   fscm_req,
  output logic   sys_rst,
  output logic   osc_enable,
  output logic   run,
  output logic   fscm_enable
);

  assign sys_rst     = holds_reset(state);
  assign osc_enable  = clocks_on(state);
  assign run         = core_runs(state);
  assign fscm_enable = (state == ST_MON) && fscm_req;

endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl
  import por_seq_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned POR_TICKS   = 3,
  parameter int unsigned BOR_TICKS   = 10,
  parameter int unsigned PWRT_UNIT   = 4,
  parameter int unsigned OSC_TIMEOUT = 50,
  parameter int unsigned MON_TICKS   = 18,
  parameter int unsigned VEC_W       = 24,
  parameter logic [VEC_W-1:0] RESET_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             por_ok,
  input  logic             bor_ok,
  input  logic [2:0]       pwrt_sel,
  input  logic             osc_ready,
  input  logic             fscm_req,
  output logic             sys_rst,
  output logic             osc_enable,
  output logic             run,
  output logic             fscm_enable,
  output logic             clk_fail,
  output logic [VEC_W-1:0] start_vec,
  output logic [2:0]       state_o
);

  stage_e           stage;
  logic [CNT_W-1:0] target;
  logic             cnt_clr;
  logic             stage_done;
  logic             supply_fault;
  logic             fail_set;

  por_seq_fsm #(
    .CNT_W(CNT_W), .POR_TICKS(POR_TICKS), .BOR_TICKS(BOR_TICKS),
    .PWRT_UNIT(PWRT_UNIT), .OSC_TIMEOUT(OSC_TIMEOUT), .MON_TICKS(MON_TICKS)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .bor_ok(bor_ok),
    .pwrt_sel(pwrt_sel), .osc_ready(osc_ready), .stage_done(stage_done),
    .state_o(stage), .target_o(target), .cnt_clr_o(cnt_clr),
    .supply_fault_o(supply_fault), .fail_set_o(fail_set),
    .clk_fail_o(clk_fail)
  );

  por_seq_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
    .target(target), .done_o(stage_done)
  );

  por_seq_outdec dec_i (
    .state(stage), .fscm_req(fscm_req), .sys_rst(sys_rst),
    .osc_enable(osc_enable), .run(run), .fscm_enable(fscm_enable)
  );

  assign start_vec = RESET_VEC;
  assign state_o   = stage;

endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       sys_rst,
  input logic       run,
  input logic       fscm_enable,
  input logic       fscm_req,
  input logic       osc_ready,
  input logic       clk_fail,
  input logic       supply_fault,
  input logic       stage_done,
  input logic       fail_set
);

  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (state == $past(state) || state == 3'd0 || state == $past(state) + 3'd1)); // R2

  AST_RELEASE_AFTER_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> ($past(state) == 3'd2 && $past(stage_done))); // R5

  AST_RUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(osc_ready)); // R7

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_fail && !supply_fault) |=> clk_fail); // R8

  AST_FAIL_BLOCKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fail |-> !run); // R8

  AST_FAIL_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_set && !supply_fault) |=> (clk_fail && state == 3'd3)); // R8

  AST_MONITOR_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fscm_enable) |-> ($past(run) && fscm_req)); // R9

  AST_FAULT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fault |=> (state == 3'd0 && sys_rst && !clk_fail)); // R10

endmodule

bind por_seq_ctrl por_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state(state_o), .sys_rst(sys_rst),
  .run(run), .fscm_enable(fscm_enable), .fscm_req(fscm_req),
  .osc_ready(osc_ready), .clk_fail(clk_fail),
  .supply_fault(supply_fault), .stage_done(stage_done), .fail_set(fail_set)
);

// File: tb/por_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module por_seq_ctrl_tb_top;

  localparam int POR_T  = 3;
  localparam int BOR_T  = 10;
  localparam int UNIT   = 4;
  localparam int OSC_TO = 50;
  localparam int MON_T  = 18;

  logic clk = 1'b0;
  logic rst_n, tick, por_ok, bor_ok, osc_ready, fscm_req;
  logic [2:0] pwrt_sel;
  logic sys_rst, osc_enable, run, fscm_enable, clk_fail;
  logic [23:0] start_vec;
  logic [2:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  por_seq_ctrl #(
    .CNT_W(16), .POR_TICKS(POR_T), .BOR_TICKS(BOR_T), .PWRT_UNIT(UNIT),
    .OSC_TIMEOUT(OSC_TO), .MON_TICKS(MON_T), .VEC_W(24), .RESET_VEC(24'h0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .por_ok(por_ok), .bor_ok(bor_ok),
    .pwrt_sel(pwrt_sel), .osc_ready(osc_ready), .fscm_req(fscm_req),
    .sys_rst(sys_rst), .osc_enable(osc_enable), .run(run),
    .fscm_enable(fscm_enable), .clk_fail(clk_fail), .start_vec(start_vec),
    .state_o(state_o)
  );

  function automatic int timer_len(input int sel);
    int v;
    if (sel == 0) return 0;
    v = UNIT;
    for (int k = 1; k < sel; k++) v = v * 2;
    return v;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic dwell(input int st, output int n);
    n = 1;
    while (state_o == 3'(st) && n < 5000) begin
      step();
      if (state_o == 3'(st)) n++;
    end
  endtask

  task automatic do_reset(input bit p, input bit b, input int sel, input bit req, input bit rdy);
    rst_n = 1'b0; tick = 1'b1; por_ok = p; bor_ok = b;
    pwrt_sel = 3'(sel); fscm_req = req; osc_ready = rdy;
    repeat (3) step();
    chk("R1", "reset stage", int'(state_o), 0);
    chk("R1", "reset sys_rst", int'(sys_rst), 1);
    chk("R1", "reset outputs", int'({osc_enable, run, fscm_enable, clk_fail}), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    // sweep every timer select
    for (int s = 0; s < 8; s++) begin
      do_reset(1'b1, 1'b1, s, s[0], 1'b0);
      dwell(0, n); chk("R3", "power-on dwell", n, POR_T + 1);
      chk("R2", "stage after 0", int'(state_o), 1);
      chk("R5", "sys_rst in stage 1", int'(sys_rst), 1);
      dwell(1, n); chk("R4", "brown-out dwell", n, BOR_T + 1);
      chk("R2", "stage after 1", int'(state_o), 2);
      dwell(2, n); chk("R5", "timer dwell", n, timer_len(s) + 1);
      chk("R2", "stage after 2", int'(state_o), 3);
      chk("R5", "sys_rst released", int'(sys_rst), 0);
      chk("R5", "osc_enable", int'(osc_enable), 1);
      repeat (s * 7) step();
      chk("R7", "still waiting for clock", int'(state_o), 3);
      osc_ready = 1'b1;
      step();
      chk("R7", "run after ready", int'(state_o), 4);
      chk("R7", "run flag", int'(run), 1);
      chk("R7", "start vector", int'(start_vec), 0);
      chk("R9", "no monitor in stage 4", int'(fscm_enable), 0);
      dwell(4, n); chk("R9", "monitor delay dwell", n, MON_T + 1);
      chk("R2", "stage after 4", int'(state_o), 5);
      chk("R9", "monitor follows request", int'(fscm_enable), int'(s[0]));
    end

    // flags held low inside their own stages, tick stall, timeout
    do_reset(1'b0, 1'b0, 7, 1'b0, 1'b0);
    repeat (20) step();
    chk("R3", "held without por_ok", int'(state_o), 0);
    por_ok = 1'b1;
    dwell(0, n); chk("R3", "dwell after por_ok rises", n, POR_T + 1);
    repeat (20) step();
    chk("R4", "held without bor_ok", int'(state_o), 1);
    bor_ok = 1'b1;
    dwell(1, n); chk("R4", "dwell after bor_ok rises", n, BOR_T + 1);
    repeat (5) step();
    tick = 1'b0;
    repeat (30) step();
    chk("R6", "frozen without tick", int'(state_o), 2);
    tick = 1'b1;
    dwell(2, n); chk("R6", "remaining timer dwell", n, timer_len(7) + 1 - 5);
    n = 1;
    while (state_o == 3'd3 && clk_fail == 1'b0 && n < 5000) begin
      step();
      if (state_o == 3'd3 && clk_fail == 1'b0) n++;
    end
    chk("R8", "cycles to timeout", n, OSC_TO + 1);
    chk("R8", "clk_fail set", int'(clk_fail), 1);
    osc_ready = 1'b1;
    repeat (10) step();
    chk("R8", "parked in wait", int'(state_o), 3);
    chk("R8", "no run after fail", int'(run), 0);
    chk("R8", "fail sticky", int'(clk_fail), 1);
    por_ok = 1'b0;
    step();
    chk("R10", "fault returns to stage 0", int'(state_o), 0);
    chk("R10", "fault clears clk_fail", int'(clk_fail), 0);
    chk("R10", "fault asserts sys_rst", int'(sys_rst), 1);

    // brown-out loss during the timer, then a full climb
    do_reset(1'b1, 1'b1, 7, 1'b1, 1'b1);
    dwell(0, n);
    dwell(1, n);
    repeat (10) step();
    bor_ok = 1'b0;
    step();
    chk("R10", "bor loss in timer", int'(state_o), 0);
    chk("R10", "sys_rst after bor loss", int'(sys_rst), 1);
    dwell(0, n); chk("R10", "restarted count, bor low in stage 0", n, POR_T + 1);
    pwrt_sel = 3'd0;
    bor_ok = 1'b1;
    dwell(1, n); chk("R4", "brown-out dwell after restart", n, BOR_T + 1);
    dwell(2, n); chk("R5", "zero-length timer", n, 1);
    dwell(3, n); chk("R7", "ready already high", n, 1);
    dwell(4, n); chk("R9", "monitor delay", n, MON_T + 1);
    chk("R9", "monitor on", int'(fscm_enable), 1);
    fscm_req = 1'b0; #1;
    chk("R9", "monitor off with request", int'(fscm_enable), 0);
    fscm_req = 1'b1; #1;
    chk("R9", "monitor back on", int'(fscm_enable), 1);
    por_ok = 1'b0;
    step();
    chk("R10", "por loss in run", int'(state_o), 0);
    chk("R10", "run dropped", int'({run, fscm_enable}), 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule